// File: doc/BRIEF.md
# Vectored Interrupt Collector

The collector gathers 128 interrupt request pins and latches each one into its own pending bit. Software steers every source either to the normal interrupt output or to the fast interrupt output. A status register holds the number of the source that should be serviced next. Software reads that number, services the source, and then writes the acknowledge register. The write retires the source and frees the status register for the next winner.

The register bus is word indexed and 32 bits wide. The index on the bus is the byte offset of the register divided by 16. Reads are combinational from the current register state. Writes, pin edges and acknowledges change the state at the next rising clock edge, and the two interrupt outputs change at that same edge.

Top module: `icoll_top`

## Requirements
- R1: Synchronous reset clears all state and drives both outputs low. After reset the status register reads 0x7F and every other readable register reads zero.
- R2: The register indices are as follows. 0 is a plain 32-bit scratch vector register. 4 is a plain 32-bit base register. 1 is the acknowledge register, which reads as zero. 2 is the control register. 7 is the read-only status register, whose low 7 bits hold a source number.
- R3: Indices 0xA to 0xD return the pin levels sampled at the last clock edge. Source n appears at bit n mod 32 of word 0xA + n/32. Writes to these indices do nothing.
- R4: Index 0x12 + n is the control register of source n. Bit 2 enables the source onto the normal output. Bit 4 steers it onto the fast output. Only these two bits are stored and read back, and bit 3 always reads zero.
- R5: A source becomes pending in two cases: its pin was low at the previous edge and is high now, or a write to its control register has bit 3 set (software trigger). A falling pin does not clear the pending bit.
- R6: The fast output is high when some pending source has bit 4 set. The normal output is high when some pending source has bit 2 set and bit 4 clear. Both outputs are registered.
- R7: At each edge the status register takes the lowest-numbered pending fast source. If there is none, it takes the lowest-numbered pending enabled source. If there is neither, it keeps its value. A pending source with neither bit set never reaches the status register.
- R8: Any write to index 1 clears the pending bit of the source named in the status register and loads the status register with 0x7F. At the following edge a new winner, if any, is selected.
- R9: If the pin of the acknowledged source is still high when the acknowledge takes effect, that source stays pending.
- R10: A control register write takes the written value. If the write changes only bit 31, from 0 to 1, bit 30 is also set to 1.
- R11: Reads of indices with no register (3, 5, 6, 8, 9, 0xE to 0x11, and 0x92 upward) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busIdx | input | 9 | Register index (byte offset divided by 16) |
| busWrite | input | 1 | Write strobe for the indexed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the indexed register |
| srcIn | input | 128 | Interrupt request pins, one per source |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
An acknowledge and a fresh request can land on the same source in the same cycle. This happens when the pin of the reported source is still high, or rises, in the cycle of the acknowledge write. The bench provokes this directly by holding pin 5 high through an acknowledge, and it also lets random pin traffic collide with random acknowledges. The bench judges the outcome by two things: the normal output staying high, and the status register naming the same source again one cycle later. Software triggers that arrive while a fast source is pending are judged through the status read order.

// File: rtl/icoll_pkg.sv
package icoll_pkg;
  localparam int NumSrc      = 128;
  localparam int SrcW        = $clog2(NumSrc);
  localparam int WordW       = 32;
  localparam int NumRawWords = NumSrc / WordW;
  localparam int RawW        = (NumRawWords > 1) ? $clog2(NumRawWords) : 1;
  localparam int IdxW        = 9;

  localparam logic [IdxW-1:0] IdxVector = IdxW'(0);
  localparam logic [IdxW-1:0] IdxAck    = IdxW'(1);
  localparam logic [IdxW-1:0] IdxCtrl   = IdxW'(2);
  localparam logic [IdxW-1:0] IdxVbase  = IdxW'(4);
  localparam logic [IdxW-1:0] IdxStat   = IdxW'(7);
  localparam int RawBase = 10;
  localparam int SrcBase = 18;

  localparam int BitEnIrq    = 2;
  localparam int BitSoft     = 3;
  localparam int BitFiq      = 4;
  localparam int CtrlSoftRst = 31;
  localparam int CtrlGate    = 30;

  typedef enum logic [2:0] {RdZero, RdVector, RdCtrl, RdVbase, RdStat, RdRaw, RdSrc} rdKind_e;

  typedef struct packed {
    logic            wrVector;
    logic            wrCtrl;
    logic            wrVbase;
    logic            ack;
    logic            wrSrc;
    rdKind_e         rdKind;
    logic [SrcW-1:0] srcIdx;
    logic [RawW-1:0] rawIdx;
  } strobe_t;

  // Lowest set bit; MSB of the result flags that one was found.
  function automatic logic [SrcW:0] firstSet(input logic [NumSrc-1:0] vec);
    logic [SrcW:0] res;
    res = '0;
    for (int i = NumSrc - 1; i >= 0; i--) begin
      if (vec[i]) res = {1'b1, SrcW'(i)};
    end
    return res;
  endfunction
endpackage

// File: rtl/icoll_ctrl.sv
module icoll_ctrl import icoll_pkg::*; (
  input  logic [IdxW-1:0] busIdx,
  input  logic            busWrite,
  output strobe_t         strobes
);
  int unsigned idxNum;
  logic inSrc, inRaw;

  always_comb begin
    idxNum = 32'(busIdx);
    inSrc  = (idxNum >= SrcBase) && (idxNum < SrcBase + NumSrc);
    inRaw  = (idxNum >= RawBase) && (idxNum < RawBase + NumRawWords);

    strobes        = '0;
    strobes.rdKind = RdZero;
    strobes.srcIdx = SrcW'(idxNum - SrcBase);
    strobes.rawIdx = RawW'(idxNum - RawBase);

    if (inSrc) begin
      strobes.rdKind = RdSrc;
      strobes.wrSrc  = busWrite;
    end else if (inRaw) begin
      strobes.rdKind = RdRaw;
    end else begin
      case (busIdx)
        IdxVector: begin strobes.rdKind = RdVector; strobes.wrVector = busWrite; end
        IdxAck:    strobes.ack = busWrite;
        IdxCtrl:   begin strobes.rdKind = RdCtrl;   strobes.wrCtrl   = busWrite; end
        IdxVbase:  begin strobes.rdKind = RdVbase;  strobes.wrVbase  = busWrite; end
        IdxStat:   strobes.rdKind = RdStat;
        default:   strobes.rdKind = RdZero;
      endcase
    end
  end
endmodule

// File: rtl/icoll_datapath.sv
module icoll_datapath import icoll_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [WordW-1:0]  wdata,
  input  logic [NumSrc-1:0] srcIn,
  output logic [WordW-1:0]  rdata,
  output logic              irqOut,
  output logic              fiqOut,
  output logic [SrcW-1:0]   statusVal
);
  logic [NumSrc-1:0] rawQ, pendQ, enIrqQ, enFiqQ;
  logic [NumSrc-1:0] pendNext, enIrqNext, enFiqNext, srcHit, ackHit, fiqCand, irqCand;
  logic [WordW-1:0]  vectorQ, ctrlQ, vbaseQ, ctrlNext;
  logic [SrcW-1:0]   statusQ, statusNext;
  logic [SrcW:0]     fiqSel, irqSel;
  logic              irqQ, fiqQ;

  always_comb begin
    srcHit = strobes.wrSrc ? (NumSrc'(1) << strobes.srcIdx) : '0;
    ackHit = strobes.ack   ? (NumSrc'(1) << statusQ)        : '0;

    enIrqNext = (enIrqQ & ~srcHit) | (srcHit & {NumSrc{wdata[BitEnIrq]}});
    enFiqNext = (enFiqQ & ~srcHit) | (srcHit & {NumSrc{wdata[BitFiq]}});

    // acknowledged source re-pends while its pin stays high
    pendNext = (pendQ & ~ackHit) | (ackHit & srcIn) | (srcIn & ~rawQ)
             | (srcHit & {NumSrc{wdata[BitSoft]}});

    fiqCand = pendNext & enFiqNext;
    irqCand = pendNext & enIrqNext & ~enFiqNext;
    fiqSel  = firstSet(fiqCand);
    irqSel  = firstSet(irqCand);

    if (strobes.ack)     statusNext = '1;
    else if (fiqSel[SrcW]) statusNext = fiqSel[SrcW-1:0];
    else if (irqSel[SrcW]) statusNext = irqSel[SrcW-1:0];
    else                 statusNext = statusQ;

    ctrlNext = wdata;
    if (((ctrlQ ^ wdata) == (WordW'(1) << CtrlSoftRst)) && !ctrlQ[CtrlSoftRst])
      ctrlNext[CtrlGate] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rawQ    <= '0;
      pendQ   <= '0;
      enIrqQ  <= '0;
      enFiqQ  <= '0;
      vectorQ <= '0;
      ctrlQ   <= '0;
      vbaseQ  <= '0;
      statusQ <= '1;
      irqQ    <= 1'b0;
      fiqQ    <= 1'b0;
    end else begin
      rawQ    <= srcIn;
      pendQ   <= pendNext;
      enIrqQ  <= enIrqNext;
      enFiqQ  <= enFiqNext;
      statusQ <= statusNext;
      irqQ    <= |irqCand;
      fiqQ    <= |fiqCand;
      if (strobes.wrVector) vectorQ <= wdata;
      if (strobes.wrVbase)  vbaseQ  <= wdata;
      if (strobes.wrCtrl)   ctrlQ   <= ctrlNext;
    end
  end

  always_comb begin
    rdata = '0;
    case (strobes.rdKind)
      RdVector: rdata = vectorQ;
      RdCtrl:   rdata = ctrlQ;
      RdVbase:  rdata = vbaseQ;
      RdStat:   rdata = WordW'(statusQ);
      RdRaw:    rdata = rawQ[32'(strobes.rawIdx) * WordW +: WordW];
      RdSrc: begin
        rdata[BitEnIrq] = enIrqQ[strobes.srcIdx];
        rdata[BitFiq]   = enFiqQ[strobes.srcIdx];
      end
      default:  rdata = '0;
    endcase
  end

  assign irqOut    = irqQ;
  assign fiqOut    = fiqQ;
  assign statusVal = statusQ;
endmodule

// File: rtl/icoll_top.sv
module icoll_top import icoll_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic [IdxW-1:0]   busIdx,
  input  logic              busWrite,
  input  logic [WordW-1:0]  busWdata,
  output logic [WordW-1:0]  busRdata,
  input  logic [NumSrc-1:0] srcIn,
  output logic              irqOut,
  output logic              fiqOut
);
  strobe_t         strobes;
  logic [SrcW-1:0] statusVal;

  icoll_ctrl ctrl_i (
    .busIdx   (busIdx),
    .busWrite (busWrite),
    .strobes  (strobes)
  );

  icoll_datapath dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wdata     (busWdata),
    .srcIn     (srcIn),
    .rdata     (busRdata),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .statusVal (statusVal)
  );
endmodule

// File: rtl/icoll_checker.sv
module icoll_checker import icoll_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic [IdxW-1:0]  busIdx,
  input logic             busWrite,
  input logic [WordW-1:0] busWdata,
  input logic [WordW-1:0] busRdata,
  input logic [SrcW-1:0]  statusVal
);
  logic inSrc, unmapped;
  always_comb begin
    inSrc = (32'(busIdx) >= SrcBase) && (32'(busIdx) < SrcBase + NumSrc);
    unmapped = (busIdx == IdxW'(3)) || (busIdx == IdxW'(5)) || (busIdx == IdxW'(6))
            || (busIdx == IdxW'(8)) || (busIdx == IdxW'(9))
            || ((32'(busIdx) >= RawBase + NumRawWords) && (32'(busIdx) < SrcBase))
            || (32'(busIdx) >= SrcBase + NumSrc);
  end

  assert_reset_status_R1: assert property (@(posedge clk)
    rst |=> statusVal == '1);

  assert_ack_status_R8: assert property (@(posedge clk) disable iff (rst)
    (busWrite && busIdx == IdxAck) |=> statusVal == '1);

  assert_src_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (!busWrite && inSrc && $past(busWrite) && busIdx == $past(busIdx))
      |-> busRdata == ($past(busWdata) & ((WordW'(1) << BitEnIrq) | (WordW'(1) << BitFiq))));

  assert_vector_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (!busWrite && busIdx == IdxVector && $past(busWrite) && $past(busIdx) == IdxVector)
      |-> busRdata == $past(busWdata));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> busRdata == '0);

  assert_ctrl_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!busWrite && busIdx == IdxCtrl && $past(busWrite) && $past(busIdx) == IdxCtrl
      && $past((busWdata ^ busRdata) == (WordW'(1) << CtrlSoftRst))
      && !$past(busRdata[CtrlSoftRst]))
      |-> busRdata[CtrlGate]);
endmodule

bind icoll_top icoll_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .busIdx    (busIdx),
  .busWrite  (busWrite),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .statusVal (statusVal)
);

// File: tb/icoll_top_tb_top.sv
module icoll_top_tb_top;
  import icoll_pkg::*;
  localparam int ClkPeriod = 10;

  logic              clk = 1'b0;
  logic              rst;
  logic [IdxW-1:0]   busIdx;
  logic              busWrite;
  logic [WordW-1:0]  busWdata;
  logic [WordW-1:0]  busRdata;
  logic [NumSrc-1:0] srcIn;
  logic              irqOut, fiqOut;

  icoll_top dut_i (.*);

  always #(ClkPeriod / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // bench model of the required behaviour
  logic [NumSrc-1:0] mPend, mEnI, mEnF, mRaw;
  logic [31:0]       mVec, mCtrl, mVbase;
  logic [6:0]        mStat;
  logic              mIrq, mFiq;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NumSrc-1:0] v);
    for (int i = 0; i < NumSrc; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(input int unsigned idx);
    if (idx >= 18 && idx < 146) begin
      logic [31:0] r;
      r = '0;
      r[2] = mEnI[idx - 18];
      r[4] = mEnF[idx - 18];
      return r;
    end
    if (idx >= 10 && idx < 14) return mRaw[(idx - 10) * 32 +: 32];
    case (idx)
      0: return mVec;
      2: return mCtrl;
      4: return mVbase;
      7: return {25'd0, mStat};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input int unsigned idx);
    if (idx >= 18 && idx < 146) return "R4 source register";
    if (idx >= 10 && idx < 14)  return "R3 raw word";
    if (idx == 7)               return "R7 status";
    if (idx == 0 || idx == 1 || idx == 2 || idx == 4) return "R2 register";
    return "R11 unmapped";
  endfunction

  // one bus cycle: drive at negedge, advance model, compare after the edge
  task automatic drive(input int unsigned idx, input bit wr, input logic [31:0] wd);
    logic [NumSrc-1:0] nPend, nEnI, nEnF, fC, iC;
    logic [31:0] nVec, nCtrl, nVbase;
    logic [6:0] nStat;
    bit ack;
    int f, q;
    @(negedge clk);
    busIdx = IdxW'(idx); busWrite = wr; busWdata = wd;
    nPend = mPend; nEnI = mEnI; nEnF = mEnF;
    nVec = mVec; nCtrl = mCtrl; nVbase = mVbase;
    ack = wr && idx == 1;
    if (ack) nPend[mStat] = srcIn[mStat];
    nPend = nPend | (srcIn & ~mRaw);
    if (wr) begin
      if (idx >= 18 && idx < 146) begin
        nEnI[idx - 18] = wd[2];
        nEnF[idx - 18] = wd[4];
        if (wd[3]) nPend[idx - 18] = 1'b1;
      end else if (idx == 0) nVec = wd;
      else if (idx == 4) nVbase = wd;
      else if (idx == 2) begin
        nCtrl = wd;
        if ((mCtrl ^ wd) == 32'h8000_0000 && !mCtrl[31]) nCtrl[30] = 1'b1;
      end
    end
    fC = nPend & nEnF;
    iC = nPend & nEnI & ~nEnF;
    f = lowest(fC); q = lowest(iC);
    if (ack) nStat = 7'h7F;
    else if (f >= 0) nStat = 7'(f);
    else if (q >= 0) nStat = 7'(q);
    else nStat = mStat;
    @(posedge clk);
    #1;
    mPend = nPend; mEnI = nEnI; mEnF = nEnF; mRaw = srcIn;
    mVec = nVec; mCtrl = nCtrl; mVbase = nVbase; mStat = nStat;
    mIrq = |iC; mFiq = |fC;
    check(32'(irqOut), 32'(mIrq), "R6 irqOut");
    check(32'(fiqOut), 32'(mFiq), "R6 fiqOut");
    check(busRdata, modelRead(idx), tagFor(idx));
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; busIdx = '0; busWrite = 1'b0; busWdata = '0; srcIn = '0;
    mPend = '0; mEnI = '0; mEnF = '0; mRaw = '0;
    mVec = '0; mCtrl = '0; mVbase = '0; mStat = 7'h7F; mIrq = 0; mFiq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    drive(7, 0, 0);
    check(busRdata, 32'h7F, "R1 status after reset");
    check(32'({irqOut, fiqOut}), 32'd0, "R1 outputs after reset");
    drive(2, 0, 0);  check(busRdata, 32'd0, "R1 control after reset");
    drive(18, 0, 0); check(busRdata, 32'd0, "R1 source 0 after reset");

    // R2 plain registers
    drive(0, 1, 32'hA5A5_0001); drive(0, 0, 0);
    check(busRdata, 32'hA5A5_0001, "R2 vector readback");
    drive(4, 1, 32'h1234_5670); drive(4, 0, 0);
    check(busRdata, 32'h1234_5670, "R2 base readback");

    // R10 soft reset sets gate; other change patterns do not
    drive(2, 1, 32'h8000_0000); drive(2, 0, 0);
    check(busRdata, 32'hC000_0000, "R10 gate forced");
    drive(2, 1, 32'h0); drive(2, 1, 32'h8000_0001); drive(2, 0, 0);
    check(busRdata, 32'h8000_0001, "R10 not only bit31");
    drive(2, 1, 32'h0);

    // R4 field readback
    drive(18 + 5, 1, 32'hFFFF_FFF7); drive(18 + 5, 0, 0);
    check(busRdata, 32'h14, "R4 only bits 2 and 4 kept");
    drive(18 + 5, 1, 32'h4); drive(18 + 5, 0, 0);
    check(busRdata, 32'h4, "R4 enable only");

    // R5 rising pin, R7 status, R6 output
    srcIn[5] = 1'b1;
    drive(7, 0, 0);
    check(busRdata, 32'd5, "R7 status names source 5");
    check(32'(irqOut), 32'd1, "R6 irq for source 5");
    // R9 ack while pin high keeps it pending
    drive(1, 1, 0);
    check(32'(irqOut), 32'd1, "R9 still pending after ack");
    drive(7, 0, 0);
    check(busRdata, 32'd5, "R9 source 5 reselected");
    // R5 falling pin keeps pending; R8 ack retires
    srcIn[5] = 1'b0;
    drive(7, 0, 0);
    check(32'(irqOut), 32'd1, "R5 falling pin keeps pending");
    drive(1, 1, 0);
    check(32'(irqOut), 32'd0, "R8 ack clears source 5");
    drive(7, 0, 0);
    check(busRdata, 32'h7F, "R8 status idle after ack");

    // R7 fast before normal, disabled never selected
    drive(18 + 10, 1, 32'hC);
    drive(18 + 40, 1, 32'h18);
    drive(18 + 3, 1, 32'h8);
    drive(7, 0, 0);
    check(busRdata, 32'd40, "R7 fast source wins");
    check(32'({irqOut, fiqOut}), 32'd3, "R6 both outputs");
    drive(1, 1, 0);
    drive(7, 0, 0);
    check(busRdata, 32'd10, "R7 normal source next, disabled skipped");
    check(32'(fiqOut), 32'd0, "R6 fast output low");
    drive(1, 1, 0);
    drive(7, 0, 0);
    check(busRdata, 32'h7F, "R7 disabled pending never reported");
    check(32'(irqOut), 32'd0, "R7 disabled source drives nothing");

    // R11 unmapped
    drive(3, 1, 32'hFFFF_FFFF); drive(3, 0, 0);
    check(busRdata, 32'd0, "R11 index 3 reads zero");
    drive(0, 0, 0);
    check(busRdata, 32'hA5A5_0001, "R11 write ignored");
    drive(146, 1, 32'hFFFF_FFFF); drive(146, 0, 0);
    check(busRdata, 32'd0, "R11 past source range");

    // R3 raw words
    srcIn[33] = 1'b1; srcIn[127] = 1'b1;
    drive(11, 0, 0);
    check(busRdata, 32'h2, "R3 source 33 in word 0xB");
    drive(13, 1, 32'h0);
    check(busRdata, 32'h8000_0000, "R3 source 127 in word 0xD");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned op, pick, src;
      op = $urandom_range(0, 9);
      pick = $urandom_range(0, 15);
      src = (pick % 8) + (pick / 8) * 60;
      if ($urandom_range(0, 3) == 0) srcIn[src] = ~srcIn[src];
      case (op)
        0, 1: drive(18 + src, 1, $urandom & 32'h1C);
        2, 3: drive(1, 1, $urandom);
        4:    drive(2, 1, ($urandom_range(0, 1) == 0) ? (mCtrl | 32'h8000_0000) : $urandom);
        5:    drive($urandom_range(0, 160), 1, $urandom);
        6:    drive(7, 0, 0);
        default: drive($urandom_range(0, 160), 0, 0);
      endcase
    end
    report();
  end
endmodule